// File: doc/BRIEF.md
# Tracking Error Health Monitor

This block watches the signed position error of one tracking converter loop and drives an active-low fault line. On every rate tick it folds the magnitude of the error into a first-order low-pass filter whose time constant is about 500 µs. It then compares the filtered magnitude with a threshold given in LSBs. A sustained excess error pulls the line low. Such an error comes from a large input step, or from an input that moves faster than the loop can follow. A brief excursion does not trip the line. Once the loop settles again, the line returns high by itself.

Two external indications also force the fault: loss of all signal inputs, and loss of reference. Loss of reference counts only when the synthesized-reference variant is built in. The analog detection that produces these two flags lies outside the block. One instance serves one channel.

Top module: `bitmon_top`

## Requirements
- R1: On reset the filter state is cleared and `fault_n` reads 1 in the first cycle after reset.
- R2: On each cycle with `tick` high, the filter state `acc` becomes `acc - (acc >> S) + |err|`. The filtered magnitude is `acc >> S`, where S = clog2(TICK_HZ·TAU_US/10^6). The default values TICK_HZ=64000 and TAU_US=500 give S=5.
- R3: On a cycle with `tick` low the filter state does not change, whatever the value of `err`.
- R4: `fault_n` is registered. In the cycle after any clock edge where the filtered magnitude is strictly greater than THRESH (default 100), it is 0. A steady error of exactly THRESH does not raise the fault; a steady error of THRESH+1 does.
- R5: `fault_n` returns to 1 without any other action, one cycle after the filtered magnitude falls to THRESH or below, provided no loss flag is set.
- R6: `los` high forces `fault_n` to 0 in the next cycle, regardless of the error.
- R7: `lor` high forces `fault_n` to 0 in the next cycle when SYNTH_REF=1. When SYNTH_REF=0, `lor` has no effect on `fault_n`.
- R8: `err` is two's complement, and a negative error acts on the filter exactly like the positive error of the same magnitude. This includes the most negative value, whose magnitude is 2^(ERR_W-1).
- R9: An error spike lasting a single tick whose magnitude is below THRESH·2^S does not raise the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Filter update strobe at TICK_HZ |
| err | input | ERR_W | Signed loop error in LSBs |
| los | input | 1 | Loss of all signal inputs |
| lor | input | 1 | Loss of reference |
| fault_n | output | 1 | Fault line, 0 = fault |

## Verification
On every cycle, the assertions check the following:
- the filter state holds when no tick arrives;
- the filter state never climbs above the largest magnitude scaled by 2^S;
- the state decays under a zero error;
- either loss flag forces the fault one cycle later.

Other behaviours need the bench's scenarios and its per-clock reference model:
- the exact threshold boundary at 100 against 101;
- the self-clearing after the loop settles;
- the symmetry of negative errors;
- the rejection of a short spike;
- the fact that `lor` has no effect when the option is off.

// File: rtl/bitmon_pkg.sv
package bitmon_pkg;
    typedef struct packed {
        logic over;
        logic sig_lost;
        logic ref_lost;
    } cause_t;

    function automatic int shift_for(input int ticks);
        return (ticks < 2) ? 1 : $clog2(ticks);
    endfunction
endpackage

// File: rtl/bitmon_mag.sv
module bitmon_mag #(
    parameter int ERR_W = 18
) (
    input  logic signed [ERR_W-1:0] err,
    output logic        [ERR_W-1:0] mag
);
    always_comb begin
        if (err[ERR_W-1]) mag = ~err + ERR_W'(1);
        else              mag = err;
    end
endmodule

// File: rtl/bitmon_iir.sv
module bitmon_iir #(
    parameter int MAG_W = 18,
    parameter int SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [MAG_W-1:0] mag,
    output logic [MAG_W-1:0] filt
);
    localparam int ACC_W = MAG_W + SHIFT;
    localparam logic [ACC_W-1:0] BOUND = ACC_W'(1) << (MAG_W - 1 + SHIFT);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } iir_t;

    iir_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick)
            st_d.acc = st_q.acc - (st_q.acc >> SHIFT) + ACC_W'(mag);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign filt = MAG_W'(st_q.acc >> SHIFT);

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.acc));
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        st_q.acc <= BOUND);
    a_r2_decay_on_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && mag == '0) |=> st_q.acc <= $past(st_q.acc));
endmodule

// File: rtl/bitmon_flag.sv
module bitmon_flag
    import bitmon_pkg::*;
#(
    parameter int MAG_W     = 18,
    parameter int THRESH    = 100,
    parameter bit SYNTH_REF = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAG_W-1:0] filt,
    input  logic             los,
    input  logic             lor,
    output logic             fault_n
);
    localparam logic [MAG_W-1:0] TH = MAG_W'(THRESH);

    typedef struct packed {
        logic fault_n;
    } flag_t;

    flag_t  fl_d, fl_q;
    cause_t cause;

    always_comb begin
        cause.over     = filt > TH;
        cause.sig_lost = los;
        cause.ref_lost = SYNTH_REF & lor;
        fl_d.fault_n   = ~(|cause);
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '{fault_n: 1'b1};
        else     fl_q <= fl_d;
    end

    assign fault_n = fl_q.fault_n;

    a_r6_los_forces: assert property (@(posedge clk) disable iff (rst)
        los |=> !fault_n);
    a_r5_self_clear: assert property (@(posedge clk) disable iff (rst)
        (filt <= TH && !los && !(SYNTH_REF && lor)) |=> fault_n);

    generate
        if (SYNTH_REF) begin : g_ref
            a_r7_lor_forces: assert property (@(posedge clk) disable iff (rst)
                lor |=> !fault_n);
        end
    endgenerate
endmodule

// File: rtl/bitmon_top.sv
module bitmon_top #(
    parameter int ERR_W     = 18,
    parameter int THRESH    = 100,
    parameter int TICK_HZ   = 64000,
    parameter int TAU_US    = 500,
    parameter bit SYNTH_REF = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic signed [ERR_W-1:0] err,
    input  logic                    los,
    input  logic                    lor,
    output logic                    fault_n
);
    localparam int TAU_TICKS = (TICK_HZ / 1000) * TAU_US / 1000;
    localparam int SHIFT     = bitmon_pkg::shift_for(TAU_TICKS);

    logic [ERR_W-1:0] mag;
    logic [ERR_W-1:0] filt;

    bitmon_mag #(.ERR_W(ERR_W)) mag_i (.err(err), .mag(mag));

    bitmon_iir #(.MAG_W(ERR_W), .SHIFT(SHIFT)) iir_i (
        .clk(clk), .rst(rst), .tick(tick), .mag(mag), .filt(filt));

    bitmon_flag #(.MAG_W(ERR_W), .THRESH(THRESH), .SYNTH_REF(SYNTH_REF)) flag_i (
        .clk(clk), .rst(rst), .filt(filt), .los(los), .lor(lor), .fault_n(fault_n));
endmodule

// File: tb/bitmon_top_tb.sv
module bitmon_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S  = 5;     // 64000 Hz * 500 us = 32 ticks
    localparam int TH = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic signed [17:0] err = '0;
    logic los = 1'b0;
    logic lor = 1'b0;
    logic fault_n, fault_n_plain;

    int errors = 0;
    int checks = 0;
    string phase = "R1 reset";

    longint m_acc = 0;
    logic exp_ref = 1'b1, exp_plain = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitmon_top #(.SYNTH_REF(1'b1)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .err(err), .los(los), .lor(lor),
        .fault_n(fault_n));
    bitmon_top #(.SYNTH_REF(1'b0)) dut_plain (
        .clk(clk), .rst(rst), .tick(tick), .err(err), .los(los), .lor(lor),
        .fault_n(fault_n_plain));

    always @(posedge clk) begin
        longint a;
        bit over;
        if (rst) begin
            m_acc = 0; exp_ref = 1'b1; exp_plain = 1'b1;
        end else begin
            over = (m_acc / (1 << S)) > TH;
            exp_ref   = !(over || los || lor);
            exp_plain = !(over || los);
            if (tick) begin
                a = (err < 0) ? -longint'(err) : longint'(err);
                m_acc = m_acc - m_acc / (1 << S) + a;
            end
        end
    end

    task automatic check(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("fault_n", fault_n, exp_ref);
            check("fault_n_plain", fault_n_plain, exp_plain);
        end
    end

    task automatic run(input int cycles, input int e, input bit tk);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            err  = 18'(e);
            tick = tk && (i % 4 == 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        phase = "R1 reset"; check("after reset", fault_n, 1'b1);

        phase = "R4 below threshold"; run(1200, 50, 1'b1);
        check("err 50", fault_n, 1'b1);
        phase = "R4 exactly threshold"; run(3000, 100, 1'b1);
        check("err 100 steady", fault_n, 1'b1);
        phase = "R4 R2 threshold plus one"; run(3000, 101, 1'b1);
        check("err 101 steady", fault_n, 1'b0);
        phase = "R5 settle"; run(2000, 0, 1'b1);
        check("recovered", fault_n, 1'b1);
        phase = "R8 negative error"; run(1500, -300, 1'b1);
        check("err -300", fault_n, 1'b0);
        phase = "R5 settle again"; run(2000, 0, 1'b1);
        check("recovered", fault_n, 1'b1);
        phase = "R3 no tick"; run(400, 30000, 1'b0);
        check("large err without tick", fault_n, 1'b1);
        phase = "R9 spike"; run(4, 3000, 1'b1); run(400, 0, 1'b1);
        check("single-tick spike", fault_n, 1'b1);
        phase = "R6 loss of signal";
        @(negedge clk); los = 1'b1;
        @(negedge clk); check("los high", fault_n, 1'b0);
        check("los high plain", fault_n_plain, 1'b0);
        los = 1'b0;
        @(negedge clk); check("los released", fault_n, 1'b1);
        phase = "R7 loss of reference";
        lor = 1'b1;
        @(negedge clk); check("lor with option", fault_n, 1'b0);
        check("lor ignored without option", fault_n_plain, 1'b1);
        lor = 1'b0;
        @(negedge clk); check("lor released", fault_n, 1'b1);
        phase = "R8 R2 most negative"; run(400, -131072, 1'b1);
        check("min error", fault_n, 1'b0);
        phase = "R5 R2 decay from max"; run(4000, 0, 1'b1);
        check("recovered from max", fault_n, 1'b1);
        phase = "R1 reset mid-fault"; run(800, 500, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; err = '0;
        check("after second reset", fault_n, 1'b1);
        run(10, 0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule